// File: doc/BRIEF.md
# I2C Target Controller with Word-Organized Byte Files

This block is the target end of an I2C link, answering the fixed 7-bit address 0x50. Bytes that the bus controller writes after a matching address are packed into a 64-byte receive file. The local logic reads that file one aligned 32-bit word at a time. A receive pointer counts every stored byte modulo 64 and never resets between transactions. The consumer compares the pointer with the value it last saw to learn how many bytes are new.

Read data goes the other way. The local logic posts bytes one at a time into a 64-byte transmit file. When the controller reads, it gets those bytes in the order they were posted. A bit-position counter records how far transmission has progressed. The only interrupt is a sticky flag. It is raised when a matched write transaction ends, by STOP or by repeated START, and it is cleared by a write-one-to-clear strobe.

SCL and SDA are sampled on the system clock through a two-stage synchronizer. The block never holds SCL low. It drives SDA only as an open-drain pull-down.

Top module: `i2ct_target`

## Requirements
- R1: After reset `sda_oe`, `irq_wr_done`, `rx_wr_ptr` and `tx_bit_pos` are 0, and every receive-file word reads 0.
- R2: An address byte whose upper seven bits equal 0x50 is acknowledged. Any other address is not acknowledged, and the rest of that transaction is ignored: no byte is stored, the pointer does not move and no interrupt is raised.
- R3: Each data byte of a matched write is acknowledged. A byte arriving when the pointer is p is stored in word p/4, lane p%4, at bits 8*(p%4)+7 down to 8*(p%4), so the file is little-endian within a word. The word is visible on `rx_word_data` when `rx_word_idx` selects it.
- R4: `rx_wr_ptr` advances by one for each stored data byte and wraps from 63 to 0. The address byte is not stored. A new transaction does not reset the pointer.
- R5: `irq_wr_done` is set when a matched write ends by STOP or repeated START. It becomes 1 on the third rising clock edge after the SDA pin change. It stays set until an `irq_clear` pulse. When a set and a clear fall on the same edge, the set wins.
- R6: After a matched read address, the block shifts bytes out MSB first, in the order they were posted. It continues as long as the controller acknowledges. After a NACK it leaves SDA released.
- R7: A one-cycle `tx_post_valid` appends `tx_post_byte` at the next transmit position. The transmit file uses the same word and lane mapping as R3.
- R8: `tx_bit_pos` counts the data bits shifted out to the controller, modulo 512, and advances by 8 for every byte read.
- R9: `sda_oe` becomes active only while the synchronized SCL is low.
- R10: A read transaction neither raises the interrupt nor moves `rx_wr_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_word_idx | input | 4 | Receive-file word select |
| rx_word_data | output | 32 | Selected receive-file word |
| rx_wr_ptr | output | 6 | Free-running receive byte pointer |
| tx_post_valid | input | 1 | Append one byte to the transmit file |
| tx_post_byte | input | 8 | Byte to append |
| tx_bit_pos | output | 9 | Count of bits shifted out, modulo 512 |
| irq_wr_done | output | 1 | Sticky write-complete interrupt |
| irq_clear | input | 1 | Write-one-to-clear for the interrupt |

## Verification
Two functions can act on the same clock edge: the interrupt being set by a detected STOP, and a local clear strobe. The bench drives SDA high to form the STOP, counts the two synchronizer stages, and raises `irq_clear` so that it spans exactly the edge where the set lands. It then requires the flag to read 1. Separate checks confirm that a clear on its own empties the flag, and that the flag reads 0 one cycle before the set edge.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ACK_A,
    LK_WR,
    LK_ACK_W,
    LK_RD,
    LK_RD_ACK
  } link_state_t;

  // lane of a byte pointer inside a 32-bit word
  function automatic logic [1:0] lane_of(input logic [1:0] ptr_lo);
    return ptr_lo;
  endfunction

  // replace one byte lane of a word (little-endian lanes)
  function automatic logic [31:0] put_lane(input logic [31:0] w,
                                           input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*lane +: 8] = b;
    return r;
  endfunction

  // extract one byte lane of a word
  function automatic logic [7:0] get_lane(input logic [31:0] w,
                                          input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

endpackage

// File: rtl/i2ct_pin_sync.sv
module i2ct_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end else begin
          scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
          sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] tx_cur_byte,
  output logic       sda_oe,
  output logic       rx_we,
  output logic [7:0] rx_byte,
  output logic       tx_adv,
  output logic       tx_bit_adv,
  output logic       wr_end,
  output logic       in_write
);
  link_state_t state;
  logic [7:0]  shreg;
  logic [2:0]  cnt;
  logic        byte_done;
  logic        rw;
  logic        nack;
  logic        bus_ev;

  assign bus_ev     = start_ev | stop_ev;
  assign wr_end     = bus_ev & in_write;
  assign rx_we      = (state == LK_WR) & scl_fall & byte_done & ~bus_ev;
  assign rx_byte    = shreg;
  assign tx_bit_adv = (state == LK_RD) & scl_fall & ~bus_ev;
  assign tx_adv     = tx_bit_adv & (cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LK_IDLE;
      shreg     <= '0;
      cnt       <= '0;
      byte_done <= 1'b0;
      rw        <= 1'b0;
      nack      <= 1'b0;
      sda_oe    <= 1'b0;
      in_write  <= 1'b0;
    end else if (start_ev) begin
      state     <= LK_ADDR;
      cnt       <= '0;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
      in_write  <= 1'b0;
    end else if (stop_ev) begin
      state    <= LK_IDLE;
      sda_oe   <= 1'b0;
      in_write <= 1'b0;
    end else begin
      case (state)
        LK_ADDR, LK_WR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_lvl};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) byte_done <= 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            if (state == LK_WR) begin
              sda_oe <= 1'b1;
              state  <= LK_ACK_W;
            end else if (shreg[7:1] == TARGET_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= shreg[0];
              state  <= LK_ACK_A;
            end else begin
              state <= LK_IDLE;
            end
          end
        end
        LK_ACK_A: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              shreg  <= tx_cur_byte;
              sda_oe <= ~tx_cur_byte[7];
              state  <= LK_RD;
            end else begin
              sda_oe   <= 1'b0;
              in_write <= 1'b1;
              state    <= LK_WR;
            end
          end
        end
        LK_ACK_W: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= LK_WR;
          end
        end
        LK_RD: begin
          if (scl_fall) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= LK_RD_ACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        LK_RD_ACK: begin
          if (scl_rise) begin
            nack <= sda_lvl;
          end else if (scl_fall) begin
            if (nack) begin
              state <= LK_IDLE;
            end else begin
              shreg  <= tx_cur_byte;
              sda_oe <= ~tx_cur_byte[7];
              cnt    <= '0;
              state  <= LK_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_rx_file.sv
module i2ct_rx_file
  import i2ct_pkg::*;
#(
  parameter int FILE_BYTES = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [7:0]                         byte_in,
  input  logic [$clog2(FILE_BYTES/4)-1:0]    rd_idx,
  output logic [31:0]                        rd_word,
  output logic [$clog2(FILE_BYTES)-1:0]      wr_ptr
);
  localparam int WORDS  = FILE_BYTES / 4;
  localparam int PTR_W  = $clog2(FILE_BYTES);
  localparam int WIDX_W = $clog2(WORDS);

  logic [31:0] mem [WORDS];
  logic [WIDX_W-1:0] wsel;

  assign wsel = wr_ptr[PTR_W-1:2];

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[g] <= '0;
        else if (we && wsel == WIDX_W'(g))
          mem[g] <= put_lane(mem[g], lane_of(wr_ptr[1:0]), byte_in);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wr_ptr <= '0;
    else if (we) wr_ptr <= wr_ptr + PTR_W'(1);
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/i2ct_tx_file.sv
module i2ct_tx_file
  import i2ct_pkg::*;
#(
  parameter int FILE_BYTES = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            post_valid,
  input  logic [7:0]                      post_byte,
  input  logic                            byte_adv,
  input  logic                            bit_adv,
  output logic [7:0]                      cur_byte,
  output logic [$clog2(FILE_BYTES)+2:0]   bit_pos
);
  localparam int WORDS  = FILE_BYTES / 4;
  localparam int PTR_W  = $clog2(FILE_BYTES);
  localparam int WIDX_W = $clog2(WORDS);

  logic [31:0]      mem [WORDS];
  logic [PTR_W-1:0] post_ptr, rd_ptr;
  logic [WIDX_W-1:0] psel;

  assign psel = post_ptr[PTR_W-1:2];

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[g] <= '0;
        else if (post_valid && psel == WIDX_W'(g))
          mem[g] <= put_lane(mem[g], lane_of(post_ptr[1:0]), post_byte);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_ptr <= '0;
      rd_ptr   <= '0;
      bit_pos  <= '0;
    end else begin
      if (post_valid) post_ptr <= post_ptr + PTR_W'(1);
      if (byte_adv)   rd_ptr   <= rd_ptr + PTR_W'(1);
      if (bit_adv)    bit_pos  <= bit_pos + (PTR_W+3)'(1);
    end
  end

  assign cur_byte = get_lane(mem[rd_ptr[PTR_W-1:2]], lane_of(rd_ptr[1:0]));
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h50,
  parameter int         FILE_BYTES  = 64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [3:0]  rx_word_idx,
  output logic [31:0] rx_word_data,
  output logic [5:0]  rx_wr_ptr,
  input  logic        tx_post_valid,
  input  logic [7:0]  tx_post_byte,
  output logic [8:0]  tx_bit_pos,
  output logic        irq_wr_done,
  input  logic        irq_clear
);
  localparam int PTR_W = $clog2(FILE_BYTES);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic rx_we, tx_adv, tx_bit_adv, wr_end, in_write;
  logic [7:0] rx_byte, tx_cur_byte;

  i2ct_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2ct_link #(.TARGET_ADDR(TARGET_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_cur_byte(tx_cur_byte), .sda_oe(sda_oe), .rx_we(rx_we),
    .rx_byte(rx_byte), .tx_adv(tx_adv), .tx_bit_adv(tx_bit_adv),
    .wr_end(wr_end), .in_write(in_write)
  );

  i2ct_rx_file #(.FILE_BYTES(FILE_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .we(rx_we), .byte_in(rx_byte),
    .rd_idx(rx_word_idx), .rd_word(rx_word_data), .wr_ptr(rx_wr_ptr)
  );

  i2ct_tx_file #(.FILE_BYTES(FILE_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .post_valid(tx_post_valid),
    .post_byte(tx_post_byte), .byte_adv(tx_adv), .bit_adv(tx_bit_adv),
    .cur_byte(tx_cur_byte), .bit_pos(tx_bit_pos)
  );

  // sticky interrupt: a set on the same edge overrides the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_wr_done <= 1'b0;
    else if (wr_end)    irq_wr_done <= 1'b1;
    else if (irq_clear) irq_wr_done <= 1'b0;
  end
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             sda_oe,
  input logic             rx_we,
  input logic [PTR_W-1:0] rx_wr_ptr,
  input logic             wr_end,
  input logic             in_write,
  input logic             irq_wr_done,
  input logic             irq_clear,
  input logic             tx_adv,
  input logic [PTR_W+2:0] tx_bit_pos
);
  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |=> rx_wr_ptr == $past(rx_wr_ptr) + PTR_W'(1));

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_we |=> $stable(rx_wr_ptr));

  assert_store_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> in_write);

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> irq_wr_done);

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !wr_end) |=> !irq_wr_done);

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_wr_done) |-> $past(wr_end));

  assert_byte_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_adv |-> tx_bit_pos[2:0] == 3'd7);
endmodule

bind i2ct_target i2ct_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .rx_we(rx_we), .rx_wr_ptr(rx_wr_ptr), .wr_end(wr_end),
  .in_write(in_write), .irq_wr_done(irq_wr_done), .irq_clear(irq_clear),
  .tx_adv(tx_adv), .tx_bit_pos(tx_bit_pos)
);

// File: tb/sim_i2ct_target.sv
`timescale 1ns/1ps
module sim_i2ct_target;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_tb = 1'b1, sda_tb = 1'b1;
  logic sda_oe;
  logic [3:0]  rx_word_idx = '0;
  logic [31:0] rx_word_data;
  logic [5:0]  rx_wr_ptr;
  logic        tx_post_valid = 1'b0;
  logic [7:0]  tx_post_byte = '0;
  logic [8:0]  tx_bit_pos;
  logic        irq_wr_done;
  logic        irq_clear = 1'b0;
  wire         sda_line = sda_tb & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_rx [64];
  int exp_ptr = 0;
  int exp_bits = 0;
  int wcount = 0;

  always #5 clk = ~clk;

  i2ct_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_line),
    .sda_oe(sda_oe), .rx_word_idx(rx_word_idx), .rx_word_data(rx_word_data),
    .rx_wr_ptr(rx_wr_ptr), .tx_post_valid(tx_post_valid),
    .tx_post_byte(tx_post_byte), .tx_bit_pos(tx_bit_pos),
    .irq_wr_done(irq_wr_done), .irq_clear(irq_clear)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_tb = 1'b1; wt(P); scl_tb = 1'b1; wt(P);
    sda_tb = 1'b0; wt(P); scl_tb = 1'b0;
  endtask

  task automatic bus_stop();
    wt(P); sda_tb = 1'b0; wt(P); scl_tb = 1'b1; wt(P);
    sda_tb = 1'b1; wt(2*P);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wt(P); sda_tb = b[i]; wt(P); scl_tb = 1'b1; wt(2*P); scl_tb = 1'b0;
    end
    wt(P); sda_tb = 1'b1; wt(P); scl_tb = 1'b1; wt(P);
    ack = ~sda_line; wt(P); scl_tb = 1'b0;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wt(2*P); scl_tb = 1'b1; wt(P); d[i] = sda_line; wt(P); scl_tb = 1'b0;
    end
    wt(P); sda_tb = nack; wt(P); scl_tb = 1'b1; wt(2*P); scl_tb = 1'b0;
    wt(P); sda_tb = 1'b1;
  endtask

  task automatic post(input logic [7:0] b);
    tx_post_valid = 1'b1; tx_post_byte = b; wt(1); tx_post_valid = 1'b0;
  endtask

  task automatic check_words(input string req);
    for (int w = 0; w < 16; w++) begin
      rx_word_idx = 4'(w); wt(1);
      chk(req, rx_word_data, {exp_rx[4*w+3], exp_rx[4*w+2], exp_rx[4*w+1], exp_rx[4*w]});
    end
  endtask

  function automatic logic [7:0] wpat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] tpat(input int k);
    return 8'((k * 91 + 5) & 255);
  endfunction

  task automatic clear_irq();
    irq_clear = 1'b1; wt(1); irq_clear = 1'b0; wt(1);
  endtask

  // matched write of len data bytes, ended by STOP
  task automatic do_write(input int len);
    logic a;
    bus_start();
    wbyte(8'hA0, a); chk("R2 addr ack", a, 1);
    for (int i = 0; i < len; i++) begin
      wbyte(wpat(wcount), a); chk("R3 data ack", a, 1);
      exp_rx[exp_ptr] = wpat(wcount); exp_ptr = (exp_ptr + 1) % 64; wcount++;
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    int tcount;
    for (int i = 0; i < 64; i++) exp_rx[i] = 8'h00;
    wt(3); rst_n = 1'b1; wt(2);

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq_wr_done, 0);
    chk("R1 rx_wr_ptr", rx_wr_ptr, 0);
    chk("R1 tx_bit_pos", tx_bit_pos, 0);
    check_words("R1 words");

    // R3 R4 R5: write sweep across the pointer wrap
    for (int len = 1; len <= 12; len++) begin
      if (len == 11) continue;
      do_write(len);
      chk("R4 ptr", rx_wr_ptr, exp_ptr);
      chk("R5 irq set on stop", irq_wr_done, 1);
      clear_irq();
      chk("R5 irq cleared", irq_wr_done, 0);
      check_words("R3 words");
    end

    // R2: foreign addresses are ignored
    foreach (d[i]) ;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ad;
      ad = (k == 0) ? 8'hA2 : (k == 1) ? 8'h50 : 8'hA1 ^ 8'h02;
      bus_start();
      wbyte(ad, a); chk("R2 foreign nack", a, 0);
      wbyte(8'h5A, a); wbyte(8'hC3, a);
      bus_stop();
      chk("R2 ptr unchanged", rx_wr_ptr, exp_ptr);
      chk("R2 no irq", irq_wr_done, 0);
    end
    check_words("R2 words unchanged");

    // R5: set and clear on the same edge, set wins
    bus_start();
    wbyte(8'hA0, a);
    wbyte(wpat(wcount), a);
    exp_rx[exp_ptr] = wpat(wcount); exp_ptr = (exp_ptr + 1) % 64; wcount++;
    wt(P); sda_tb = 1'b0; wt(P); scl_tb = 1'b1; wt(P);
    sda_tb = 1'b1;            // stop edge on the pins
    wt(2);
    chk("R5 irq not yet set", irq_wr_done, 0);
    irq_clear = 1'b1; wt(1); irq_clear = 1'b0;
    chk("R5 set wins over clear", irq_wr_done, 1);
    wt(1);
    chk("R5 irq sticky", irq_wr_done, 1);
    clear_irq();
    chk("R5 clear alone", irq_wr_done, 0);

    // R6 R7 R8 R10: post then read sweeps
    tcount = 0;
    for (int len = 1; len <= 12; len++) begin
      for (int i = 0; i < len; i++) post(tpat(tcount + i));
      bus_start();
      wbyte(8'hA1, a); chk("R2 read addr ack", a, 1);
      for (int i = 0; i < len; i++) begin
        rbyte(i == len - 1, d);
        chk("R6 R7 read data", d, tpat(tcount + i));
        exp_bits = (exp_bits + 8) % 512;
      end
      wt(P);
      chk("R6 released after nack", sda_oe, 0);
      bus_stop();
      tcount += len;
      chk("R8 bit position", tx_bit_pos, exp_bits);
      chk("R10 no irq on read", irq_wr_done, 0);
      chk("R10 ptr unchanged", rx_wr_ptr, exp_ptr);
    end

    // R5: repeated START ends a write, then a read follows
    post(8'h3C);
    bus_start();
    wbyte(8'hA0, a);
    wbyte(wpat(wcount), a);
    exp_rx[exp_ptr] = wpat(wcount); exp_ptr = (exp_ptr + 1) % 64; wcount++;
    bus_start();
    chk("R5 irq on repeated start", irq_wr_done, 1);
    wbyte(8'hA1, a);
    rbyte(1'b1, d);
    chk("R6 read after restart", d, 8'h3C);
    bus_stop();
    chk("R4 ptr after restart", rx_wr_ptr, exp_ptr);
    check_words("R3 final words");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule